// File: doc/BRIEF.md
# Two-Level Data Translation Lookaside Buffer

This block translates a virtual address and a context number into a 43-bit physical address. A lookup is answered in the same cycle it is presented. The answer comes first from a small fully associative micro-TLB. If the micro-TLB has no match, it comes from a main TLB made of two parts that are searched in parallel. The first main part is fully associative and holds locked entries and every page larger than 8 KB. The second main part is a two-way set-associative array that holds unlocked 8 KB pages only. When a lookup misses the micro-TLB and exactly one main entry matches, that entry is copied into the micro-TLB at the next clock edge.

Translations enter through a single write port. Each write carries a virtual page, a context, a 47-bit physical-address field, a two-bit page-size code and a lock bit. The write port decides which main part receives the entry. A match in more than one main entry is reported as a multi-hit. This check is made only when the main TLB is consulted, so a stale duplicate does not show while the micro-TLB still answers for that page. A flush input clears the micro-TLB and every unlocked main entry.

Top module: `dtlb_two_level`

## Requirements
- R1: With `lk_valid` low, `hit`, `miss`, `multi_hit` and `pa` are all zero. With `lk_valid` high, exactly one of `hit` and `miss` is set in the same cycle. An entry matches only when its valid bit is set, its context equals `lk_ctx` and its virtual page equals the lookup's.
- R2: A hit returns its translation combinationally in the lookup cycle. `pa` is the entry's frame bits above the page offset, joined with the lookup address bits below it. For 8 KB pages the offset is bits 12:0.
- R3: On a micro-TLB miss with exactly one main match, the entry is copied into the micro-TLB at the closing clock edge. Copies replace micro-TLB slots in round-robin order. Later writes to the main TLB do not change copies already held.
- R4: A lookup that matches in the micro-TLB reports hit with that copy's address and never reports multi-hit, even when the main TLB holds several matches.
- R5: When the micro-TLB misses and two or more main entries match, `multi_hit` and `miss` are set, `pa` is zero and nothing is copied into the micro-TLB.
- R6: A write with the lock bit set goes into the fully associative part. The entry stays valid through later flushes.
- R7: An unlocked write with size code 0 (8 KB) goes into the set-associative part. Size codes 1, 2 and 3 (64 KB, 512 KB, 4 MB) go into the fully associative part. The page offset width is 13 + 3 × code bits.
- R8: The fully associative part replaces entries in round-robin order and skips valid locked entries. If all of its entries are valid and locked, a write aimed at it is dropped and `wr_err` pulses for the one cycle after the write.
- R9: Bits 46:43 of `wr_data` are ignored. Writing them as ones gives the same translation as writing them as zeros.
- R10: `flush` invalidates every micro-TLB entry and every unlocked main entry at the clock edge.
- R11: When `flush` and a refilling lookup fall in the same cycle, the lookup result of that cycle is still reported, but no copy is kept.
- R12: The set-associative part is indexed by virtual address bits 18:13. A write fills an invalid way of the set first. When both ways are valid, it replaces ways alternately, starting with way 0.
- R13: Pages of 64 KB and 4 MB translate with 16-bit and 22-bit offsets respectively.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flush | input | 1 | Invalidate micro-TLB and unlocked main entries |
| lk_valid | input | 1 | Lookup request |
| lk_va | input | 44 | Lookup virtual address |
| lk_ctx | input | 13 | Lookup context |
| wr_en | input | 1 | Write a translation |
| wr_va | input | 44 | Virtual address of the written page |
| wr_ctx | input | 13 | Context of the written page |
| wr_data | input | 47 | Physical address field; bits 46:43 ignored |
| wr_size | input | 2 | Page size code (0: 8 KB, 1: 64 KB, 2: 512 KB, 3: 4 MB) |
| wr_lock | input | 1 | Lock the entry |
| hit | output | 1 | Translation found |
| miss | output | 1 | No usable translation |
| multi_hit | output | 1 | Several main-TLB entries matched |
| pa | output | 43 | Translated physical address |
| wr_err | output | 1 | Previous write dropped, fully associative part all locked |

## Verification
Flush and micro-TLB refill are the two functions that collide. The bench presents a lookup that would copy an unlocked set-associative entry into the micro-TLB, and it raises `flush` in that same cycle. It expects that cycle's lookup to report the hit with its address. It then expects a repeat lookup of that page on the next cycle to miss. A kept copy would have answered from the micro-TLB, so the repeat lookup shows whether flush won.

// File: rtl/dtlb_pkg.sv
package dtlb_pkg;
   parameter int VA_W      = 44;
   parameter int CTX_W     = 13;
   parameter int PA_W      = 43;
   parameter int PAFIELD_W = 47;
   parameter int BASE_OFF  = 13;
   parameter int SIZE_STEP = 3;

   typedef struct packed {
      logic                     valid;
      logic                     lock;
      logic [1:0]               size;
      logic [CTX_W-1:0]         ctx;
      logic [VA_W-1:BASE_OFF]   vpn;
      logic [PA_W-1:BASE_OFF]   ppn;
   } tte_t;

   function automatic int unsigned off_bits(input logic [1:0] sz);
      return BASE_OFF + SIZE_STEP * int'(sz);
   endfunction

   function automatic logic tte_match(input tte_t e, input logic [VA_W-1:0] va,
                                      input logic [CTX_W-1:0] ctx);
      logic [VA_W-1:0] m;
      m = {VA_W{1'b1}} << off_bits(e.size);
      return e.valid && (e.ctx == ctx) &&
             ((({e.vpn, {BASE_OFF{1'b0}}}) ^ va) & m) == '0;
   endfunction

   function automatic logic [PA_W-1:0] tte_pa(input tte_t e, input logic [VA_W-1:0] va);
      logic [PA_W-1:0] m;
      m = {PA_W{1'b1}} << off_bits(e.size);
      return ({e.ppn, {BASE_OFF{1'b0}}} & m) | (va[PA_W-1:0] & ~m);
   endfunction
endpackage

// File: rtl/dtlb_micro.sv
module dtlb_micro
   import dtlb_pkg::*;
#(
   parameter int N = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             flush,
   input  logic [VA_W-1:0]  lk_va,
   input  logic [CTX_W-1:0] lk_ctx,
   input  logic             fill_en,
   input  tte_t             fill_tte,
   output logic             hit,
   output tte_t             hit_tte
);
   localparam int IW = $clog2(N);

   tte_t          ent_q [N];
   logic [IW-1:0] ptr_q;
   logic [N-1:0]  match;

   for (genvar i = 0; i < N; i++) begin : g_cmp
      assign match[i] = tte_match(ent_q[i], lk_va, lk_ctx);
   end

   always_comb begin
      hit_tte = '0;
      for (int i = 0; i < N; i++) begin
         if (match[i]) hit_tte = tte_t'(hit_tte | ent_q[i]);
      end
   end
   assign hit = |match;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < N; i++) ent_q[i].valid <= 1'b0;
         ptr_q <= '0;
      end else if (flush) begin
         for (int i = 0; i < N; i++) ent_q[i].valid <= 1'b0;
      end else if (fill_en) begin
         ent_q[ptr_q] <= fill_tte;
         ptr_q        <= ptr_q + 1'b1;
      end
   end
endmodule

// File: rtl/dtlb_assoc.sv
module dtlb_assoc
   import dtlb_pkg::*;
#(
   parameter int N = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             flush,
   input  logic             wr_en,
   input  tte_t             wr_tte,
   input  logic [VA_W-1:0]  lk_va,
   input  logic [CTX_W-1:0] lk_ctx,
   output logic             any,
   output logic             multi,
   output tte_t             hit_tte,
   output logic             full_err
);
   localparam int IW = $clog2(N);

   tte_t          ent_q [N];
   logic [IW-1:0] ptr_q;
   logic [N-1:0]  match;
   logic          found;
   logic [IW-1:0] vic;
   logic [IW-1:0] idx;

   for (genvar i = 0; i < N; i++) begin : g_cmp
      assign match[i] = tte_match(ent_q[i], lk_va, lk_ctx);
   end

   always_comb begin
      hit_tte = '0;
      for (int i = 0; i < N; i++) begin
         if (match[i]) hit_tte = tte_t'(hit_tte | ent_q[i]);
      end
   end
   assign any   = |match;
   assign multi = (match & (match - 1'b1)) != '0;

   always_comb begin
      found = 1'b0;
      vic   = '0;
      idx   = '0;
      for (int k = 0; k < N; k++) begin
         idx = ptr_q + IW'(k);
         if (!found && !(ent_q[idx].valid && ent_q[idx].lock)) begin
            found = 1'b1;
            vic   = idx;
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < N; i++) begin
            ent_q[i].valid <= 1'b0;
            ent_q[i].lock  <= 1'b0;
         end
         ptr_q    <= '0;
         full_err <= 1'b0;
      end else begin
         if (flush) begin
            for (int i = 0; i < N; i++) begin
               if (!ent_q[i].lock) ent_q[i].valid <= 1'b0;
            end
         end
         if (wr_en && found) begin
            ent_q[vic] <= wr_tte;
            ptr_q      <= vic + 1'b1;
         end
         full_err <= wr_en && !found;
      end
   end
endmodule

// File: rtl/dtlb_setassoc.sv
module dtlb_setassoc
   import dtlb_pkg::*;
#(
   parameter int SETS = 64
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             flush,
   input  logic             wr_en,
   input  tte_t             wr_tte,
   input  logic [VA_W-1:0]  lk_va,
   input  logic [CTX_W-1:0] lk_ctx,
   output logic             any,
   output logic             multi,
   output tte_t             hit_tte
);
   localparam int SW   = $clog2(SETS);
   localparam int WAYS = 2;

   tte_t            way_q [WAYS][SETS];
   logic [SETS-1:0] vic_q;
   logic [SW-1:0]   li, wi;
   logic            m0, m1, wway;

   assign li = lk_va[BASE_OFF +: SW];
   assign wi = wr_tte.vpn[BASE_OFF +: SW];

   assign m0      = tte_match(way_q[0][li], lk_va, lk_ctx);
   assign m1      = tte_match(way_q[1][li], lk_va, lk_ctx);
   assign any     = m0 | m1;
   assign multi   = m0 & m1;
   assign hit_tte = m0 ? way_q[0][li] : way_q[1][li];

   assign wway = !way_q[0][wi].valid ? 1'b0 :
                 !way_q[1][wi].valid ? 1'b1 : vic_q[wi];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int w = 0; w < WAYS; w++)
            for (int s = 0; s < SETS; s++) way_q[w][s].valid <= 1'b0;
         vic_q <= '0;
      end else begin
         if (flush) begin
            for (int w = 0; w < WAYS; w++)
               for (int s = 0; s < SETS; s++) way_q[w][s].valid <= 1'b0;
         end
         if (wr_en) begin
            way_q[wway][wi] <= wr_tte;
            if (way_q[0][wi].valid && way_q[1][wi].valid) vic_q[wi] <= ~vic_q[wi];
         end
      end
   end
endmodule

// File: rtl/dtlb_two_level.sv
module dtlb_two_level
   import dtlb_pkg::*;
#(
   parameter int UT_N    = 32,
   parameter int FA_N    = 16,
   parameter int SA_SETS = 64
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 flush,
   input  logic                 lk_valid,
   input  logic [VA_W-1:0]      lk_va,
   input  logic [CTX_W-1:0]     lk_ctx,
   input  logic                 wr_en,
   input  logic [VA_W-1:0]      wr_va,
   input  logic [CTX_W-1:0]     wr_ctx,
   input  logic [PAFIELD_W-1:0] wr_data,
   input  logic [1:0]           wr_size,
   input  logic                 wr_lock,
   output logic                 hit,
   output logic                 miss,
   output logic                 multi_hit,
   output logic [PA_W-1:0]      pa,
   output logic                 wr_err
);
   localparam int SA_IW = $clog2(SA_SETS);

   if (UT_N < 2 || (UT_N & (UT_N - 1)) != 0) begin : g_bad_ut
      $error("UT_N must be a power of two of at least 2");
   end
   if (FA_N < 2 || (FA_N & (FA_N - 1)) != 0) begin : g_bad_fa
      $error("FA_N must be a power of two of at least 2");
   end
   if (SA_SETS < 2 || (SA_SETS & (SA_SETS - 1)) != 0) begin : g_bad_sa
      $error("SA_SETS must be a power of two of at least 2");
   end
   if (BASE_OFF + SA_IW > VA_W || VA_W < PA_W) begin : g_bad_w
      $error("address widths inconsistent with set index");
   end

   tte_t wr_tte, fa_tte, sa_tte, u_tte, main_tte;
   logic to_fa, fa_any, fa_multi, sa_any, sa_multi, u_hit;
   logic main_multi, main_one, fill;
   logic unused_bits;

   assign wr_tte      = '{valid: 1'b1, lock: wr_lock, size: wr_size, ctx: wr_ctx,
                          vpn: wr_va[VA_W-1:BASE_OFF], ppn: wr_data[PA_W-1:BASE_OFF]};
   assign unused_bits = ^{wr_data[PAFIELD_W-1:PA_W], wr_data[BASE_OFF-1:0], wr_va[BASE_OFF-1:0]};
   assign to_fa       = wr_lock | (wr_size != 2'd0);

   dtlb_micro #(.N(UT_N)) u_micro (
      .clk(clk), .rst_n(rst_n), .flush(flush), .lk_va(lk_va), .lk_ctx(lk_ctx),
      .fill_en(fill), .fill_tte(main_tte), .hit(u_hit), .hit_tte(u_tte)
   );

   dtlb_assoc #(.N(FA_N)) u_fa (
      .clk(clk), .rst_n(rst_n), .flush(flush), .wr_en(wr_en && to_fa), .wr_tte(wr_tte),
      .lk_va(lk_va), .lk_ctx(lk_ctx), .any(fa_any), .multi(fa_multi),
      .hit_tte(fa_tte), .full_err(wr_err)
   );

   dtlb_setassoc #(.SETS(SA_SETS)) u_sa (
      .clk(clk), .rst_n(rst_n), .flush(flush), .wr_en(wr_en && !to_fa), .wr_tte(wr_tte),
      .lk_va(lk_va), .lk_ctx(lk_ctx), .any(sa_any), .multi(sa_multi), .hit_tte(sa_tte)
   );

   assign main_multi = fa_multi | sa_multi | (fa_any & sa_any);
   assign main_one   = (fa_any | sa_any) & ~main_multi;
   assign main_tte   = fa_any ? fa_tte : sa_tte;

   assign hit       = lk_valid & (u_hit | main_one);
   assign miss      = lk_valid & ~hit;
   assign multi_hit = lk_valid & ~u_hit & main_multi;
   assign fill      = lk_valid & ~u_hit & main_one & ~flush;

   always_comb begin
      if (!lk_valid)     pa = '0;
      else if (u_hit)    pa = tte_pa(u_tte, lk_va);
      else if (main_one) pa = tte_pa(main_tte, lk_va);
      else               pa = '0;
   end
endmodule

// File: rtl/dtlb_two_level_chk.sv
module dtlb_two_level_chk
   import dtlb_pkg::*;
(
   input logic            clk,
   input logic            rst_n,
   input logic            lk_valid,
   input logic [VA_W-1:0] lk_va,
   input logic            hit,
   input logic            miss,
   input logic            multi_hit,
   input logic [PA_W-1:0] pa,
   input logic            wr_en,
   input logic            wr_err
);
   assert_one_outcome_R1: assert property (@(posedge clk) disable iff (!rst_n)
      lk_valid |-> (hit ^ miss));

   assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
      !lk_valid |-> (!hit && !miss && !multi_hit && pa == '0));

   assert_offset_kept_R2: assert property (@(posedge clk) disable iff (!rst_n)
      hit |-> pa[BASE_OFF-1:0] == lk_va[BASE_OFF-1:0]);

   assert_multi_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
      multi_hit |-> (miss && pa == '0));

   assert_err_after_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
      wr_err |-> $past(wr_en));
endmodule

bind dtlb_two_level dtlb_two_level_chk u_chk (
   .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_va(lk_va), .hit(hit),
   .miss(miss), .multi_hit(multi_hit), .pa(pa), .wr_en(wr_en), .wr_err(wr_err)
);

// File: tb/dtlb_two_level_test.sv
module dtlb_two_level_test;
   import dtlb_pkg::*;

   typedef struct {
      logic            h;
      logic            mu;
      logic [PA_W-1:0] p;
      string           req;
   } exp_t;

   logic                 clk = 1'b0;
   logic                 rst_n = 1'b0;
   logic                 flush = 1'b0;
   logic                 lk_valid = 1'b0;
   logic [VA_W-1:0]      lk_va = '0;
   logic [CTX_W-1:0]     lk_ctx = '0;
   logic                 wr_en = 1'b0;
   logic [VA_W-1:0]      wr_va = '0;
   logic [CTX_W-1:0]     wr_ctx = '0;
   logic [PAFIELD_W-1:0] wr_data = '0;
   logic [1:0]           wr_size = '0;
   logic                 wr_lock = 1'b0;
   logic                 hit, miss, multi_hit, wr_err;
   logic [PA_W-1:0]      pa;

   int   checks = 0;
   int   errs = 0;
   exp_t sb[$];

   always #5 clk = ~clk;

   dtlb_two_level uut (
      .clk(clk), .rst_n(rst_n), .flush(flush), .lk_valid(lk_valid), .lk_va(lk_va),
      .lk_ctx(lk_ctx), .wr_en(wr_en), .wr_va(wr_va), .wr_ctx(wr_ctx), .wr_data(wr_data),
      .wr_size(wr_size), .wr_lock(wr_lock), .hit(hit), .miss(miss),
      .multi_hit(multi_hit), .pa(pa), .wr_err(wr_err)
   );

   task automatic check(input logic ok, input string req, input string what,
                        input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (!ok) begin
         errs++;
         $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   // monitor: compare each presented lookup against the scoreboard head
   always @(negedge clk) begin
      #3;
      if (lk_valid) begin
         if (sb.size() == 0) begin
            check(1'b0, "R1", "unexpected lookup", 64'(hit), 64'd0);
         end else begin
            exp_t e;
            e = sb.pop_front();
            check(hit == e.h, e.req, "hit", 64'(hit), 64'(e.h));
            check(miss == !e.h, e.req, "miss", 64'(miss), 64'(!e.h));
            check(multi_hit == e.mu, e.req, "multi_hit", 64'(multi_hit), 64'(e.mu));
            check(pa == e.p, e.req, "pa", 64'(pa), 64'(e.p));
         end
      end
   end

   task automatic look(input logic [VA_W-1:0] va, input logic [CTX_W-1:0] ctx,
                       input logic eh, input logic emu, input logic [PA_W-1:0] ep,
                       input string req, input logic with_flush = 1'b0);
      exp_t e;
      @(negedge clk);
      wr_en    = 1'b0;
      flush    = with_flush;
      lk_valid = 1'b1;
      lk_va    = va;
      lk_ctx   = ctx;
      e.h = eh; e.mu = emu; e.p = ep; e.req = req;
      sb.push_back(e);
      @(negedge clk);
      lk_valid = 1'b0;
      flush    = 1'b0;
   endtask

   task automatic write(input logic [VA_W-1:0] va, input logic [CTX_W-1:0] ctx,
                        input logic [PAFIELD_W-1:0] data, input logic [1:0] sz,
                        input logic lk, input logic eerr, input string req);
      @(negedge clk);
      lk_valid = 1'b0;
      wr_en = 1'b1; wr_va = va; wr_ctx = ctx; wr_data = data; wr_size = sz; wr_lock = lk;
      @(negedge clk);
      wr_en = 1'b0;
      #3;
      check(wr_err == eerr, req, "wr_err", 64'(wr_err), 64'(eerr));
   endtask

   task automatic do_flush();
      @(negedge clk);
      lk_valid = 1'b0;
      flush = 1'b1;
      @(negedge clk);
      flush = 1'b0;
   endtask

   task automatic finish_run();
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
   endtask

   initial begin
      #2_000_000;
      checks++;
      errs++;
      $display("FAIL watchdog: actual=running expected=done");
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R1: reset state and idle outputs
      #3;
      check(!hit && !miss && !multi_hit && pa == '0 && !wr_err, "R1", "idle outputs",
            {hit, miss, multi_hit, wr_err}, 64'd0);
      look(44'h000_1000_2000, 13'd5, 1'b0, 1'b0, '0, "R1");

      // R2 R7 R9: unlocked 8 KB page into set part, upper data bits set
      write(44'h000_0000_4000, 13'd5, {4'hF, 43'h12_3456_6000}, 2'd0, 1'b0, 1'b0, "R9");
      look(44'h000_0000_4123, 13'd5, 1'b1, 1'b0, 43'h12_3456_6123, "R2");
      // R3 R4: locked duplicate added; micro copy still answers, no multi-hit
      write(44'h000_0000_4000, 13'd5, 47'h0_0000_A000, 2'd0, 1'b1, 1'b0, "R6");
      look(44'h000_0000_4123, 13'd5, 1'b1, 1'b0, 43'h12_3456_6123, "R4");
      // R10 R6: flush removes unlocked copy, locked entry survives
      do_flush();
      look(44'h000_0000_4123, 13'd5, 1'b1, 1'b0, 43'h00_0000_A123, "R10");
      write(44'h000_0000_4000, 13'd5, 47'h0_0000_C000, 2'd0, 1'b1, 1'b0, "R6");
      look(44'h000_0000_4123, 13'd5, 1'b1, 1'b0, 43'h00_0000_A123, "R3");
      // R5: two locked duplicates after micro flush
      do_flush();
      look(44'h000_0000_4123, 13'd5, 1'b0, 1'b1, '0, "R5");
      look(44'h000_0000_4123, 13'd5, 1'b0, 1'b1, '0, "R5");

      // R13 R7: large pages, context mismatch
      write(44'h000_0123_0000, 13'd5, 47'h0_0045_0000, 2'd1, 1'b0, 1'b0, "R7");
      look(44'h000_0123_ABCD, 13'd5, 1'b1, 1'b0, 43'h00_0045_ABCD, "R13");
      look(44'h000_0123_ABCD, 13'd6, 1'b0, 1'b0, '0, "R1");
      write(44'h000_0C00_0000, 13'd5, 47'h0_0800_0000, 2'd3, 1'b0, 1'b0, "R7");
      look(44'h000_0C3F_FFFF, 13'd5, 1'b1, 1'b0, 43'h00_083F_FFFF, "R13");

      // R12: three pages in set 1, third evicts the first
      write(44'h000_1000_2000, 13'd7, 47'h0_0010_0000, 2'd0, 1'b0, 1'b0, "R12");
      write(44'h000_2000_2000, 13'd7, 47'h0_0020_0000, 2'd0, 1'b0, 1'b0, "R12");
      write(44'h000_3000_2000, 13'd7, 47'h0_0030_0000, 2'd0, 1'b0, 1'b0, "R12");
      look(44'h000_1000_2005, 13'd7, 1'b0, 1'b0, '0, "R12");
      look(44'h000_2000_2005, 13'd7, 1'b1, 1'b0, 43'h00_0020_0005, "R12");
      look(44'h000_3000_2005, 13'd7, 1'b1, 1'b0, 43'h00_0030_0005, "R12");

      // R8: unlocked entry then fourteen locked writes fill every slot
      write(44'h000_0200_0000, 13'd9, 47'h0_0050_0000, 2'd1, 1'b0, 1'b0, "R8");
      for (int i = 0; i < 14; i++) begin
         write(44'h000_0100_0000 + 44'(i << 13), 13'd9, 47'h0_4000_0000 + 47'(i << 13),
               2'd0, 1'b1, 1'b0, "R8");
      end
      look(44'h000_0200_0010, 13'd9, 1'b0, 1'b0, '0, "R8");
      look(44'h000_0101_A010, 13'd9, 1'b1, 1'b0, 43'h00_4001_A010, "R8");
      write(44'h000_0300_0000, 13'd9, 47'h0_0060_0000, 2'd0, 1'b1, 1'b1, "R8");
      look(44'h000_0300_0000, 13'd9, 1'b0, 1'b0, '0, "R8");
      // R7: unlocked 8 KB still accepted by the set part, larger one refused
      write(44'h000_7000_0000, 13'd9, 47'h0_0099_0000, 2'd0, 1'b0, 1'b0, "R7");
      look(44'h000_7000_0042, 13'd9, 1'b1, 1'b0, 43'h00_0099_0042, "R7");
      write(44'h000_0800_0000, 13'd9, 47'h0_0100_0000, 2'd2, 1'b0, 1'b1, "R7");
      look(44'h000_0800_0000, 13'd9, 1'b0, 1'b0, '0, "R7");

      // R11: flush in the refill cycle wins over the copy
      write(44'h000_5000_0000, 13'd11, 47'h0_0007_0000, 2'd0, 1'b0, 1'b0, "R11");
      look(44'h000_5000_0044, 13'd11, 1'b1, 1'b0, 43'h00_0007_0044, "R11", 1'b1);
      look(44'h000_5000_0044, 13'd11, 1'b0, 1'b0, '0, "R11");

      repeat (2) @(negedge clk);
      check(sb.size() == 0, "R1", "scoreboard drained", 64'(sb.size()), 64'd0);
      finish_run();
   end
endmodule